// File: doc/BRIEF.md
# Per-Port Segment Pool Allocator

The block shares a fixed pool of 508 buffer segments, each 256 bytes, among the logical channels of one egress physical port. A static size code chosen once after reset sets how many channels the port may use and the most segments any single channel may own. Software then gives each channel a segment allocation and two free-segment thresholds through a small write port, and turns channels on and off.

While a channel runs, take and release strobes move its occupied-segment count. The block compares the segments left in each channel's allocation against its two thresholds and drives registered hungry and starving backpressure flags back toward the ingress side. Writes that would break the rules are dropped: an allocation over the per-channel cap or one that would take the summed allocations past the pool size pulses an allocation error, and turning on a channel whose index is outside the size code's range pulses a channel error.

Top module: `seg_pool_alloc`

## Requirements
- R1: After reset the size code output `code_o` reads 3'b011, `total_o` is 0, both error pulses are 0 and every hungry and starving flag is 0.
- R2: The size code sets the channel limit and per-channel cap: 0 gives 1 channel and 508 segments, 1 gives 4 and 256, 2 gives 8 and 128, 3 gives 16 and 64, 4 gives 32 and 32, 5 gives 64 and 16; the effective channel limit is the smaller of that count and the number of channels built.
- R3: The first `code_we_i` after reset carrying a code from 0 to 5 is taken and locks the code; later writes are ignored, and codes 6 and 7 are ignored without locking.
- R4: A configuration write with `cfg_op_i` = 2'b00 and `cfg_data_i[0]` = 1 turns a channel on; if the channel index is at or above the effective limit the write is dropped, the channel stays off and `ch_err_o` is 1 for the one cycle after the write. `cfg_data_i[0]` = 0 turns the channel off.
- R5: An allocation write (`cfg_op_i` = 2'b01, count in `cfg_data_i`) to a channel that is on is ignored with no error; to a channel that is off it replaces that channel's allocation and `total_o` follows.
- R6: An allocation above the per-channel cap is dropped and `alloc_err_o` is 1 for the one cycle after the write.
- R7: An allocation that would make the sum of all channel allocations exceed 508 is dropped with the same `alloc_err_o` pulse; `total_o` always shows the sum and never exceeds 508.
- R8: A take strobe raises a running channel's occupied count by one unless it already equals the allocation; a release lowers it by one unless it is 0; strobes to a channel that is off change nothing.
- R9: A channel's `starving_o` bit is 1 exactly when the channel is on and allocation minus occupied count is at or below the starving threshold (`cfg_op_i` = 2'b11), updated at the clock edge that applies the strobe or write.
- R10: A channel's `hungry_o` bit follows the same rule with the separately written hungry threshold (`cfg_op_i` = 2'b10).
- R11: Turning a channel off clears both its flags at the same edge and resets its occupied count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_we_i | input | 1 | Size code write strobe |
| code_i | input | 3 | Size code value |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_op_i | input | 2 | 00 on/off, 01 allocation, 10 hungry threshold, 11 starving threshold |
| cfg_ch_i | input | 6 | Channel index of the write |
| cfg_data_i | input | SEG_W | Write value (bit 0 for on/off) |
| take_i | input | 1 | Segment take strobe |
| take_ch_i | input | 6 | Channel of the take |
| rel_i | input | 1 | Segment release strobe |
| rel_ch_i | input | 6 | Channel of the release |
| code_o | output | 3 | Current size code |
| total_o | output | SEG_W | Sum of all channel allocations |
| alloc_err_o | output | 1 | Allocation error pulse |
| ch_err_o | output | 1 | Channel range error pulse |
| hungry_o | output | NCH | Per-channel hungry flags |
| starving_o | output | NCH | Per-channel starving flags |

## Verification
The bench builds the block with the full 508-segment pool but only 8 channels, so the channel limit is clipped for the larger size codes and index 8 sits just past the built range. With that small channel set it resets once per size code 0 to 5 and probes both sides of each cap and each channel limit, then walks one channel through every occupancy from empty to past full and back, so each threshold crossing is seen at its exact count. The pool-total boundary is reached by filling several channels to exactly 508 and one segment more.

// File: rtl/seg_pool_pkg.sv
package seg_pool_pkg;
  localparam int CH_IDX_W = 6;
  localparam logic [2:0] CODE_RST = 3'b011;
  localparam logic [2:0] CODE_MAX = 3'd5;

  typedef enum logic [1:0] {
    OP_EN    = 2'b00,
    OP_ALLOC = 2'b01,
    OP_THR_H = 2'b10,
    OP_THR_S = 2'b11
  } cfg_op_e;
endpackage

// File: rtl/seg_pool_chan.sv
module seg_pool_chan #(
  parameter int SEG_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_set_i,
  input  logic             en_clr_i,
  input  logic             m_we_i,
  input  logic             thr_h_we_i,
  input  logic             thr_s_we_i,
  input  logic [SEG_W-1:0] data_i,
  input  logic             take_i,
  input  logic             rel_i,
  output logic             en_o,
  output logic [SEG_W-1:0] m_o,
  output logic             hungry_o,
  output logic             starving_o
);
  logic             en_q, en_d;
  logic [SEG_W-1:0] occ_q, occ_d, m_q, m_d, thr_h_q, thr_h_d, thr_s_q, thr_s_d, free_d;
  logic             take_ok, rel_ok, hungry_q, starving_q;

  assign take_ok = take_i & en_q & (occ_q < m_q);
  assign rel_ok  = rel_i & (occ_q != '0);

  always_comb begin
    en_d    = en_set_i ? 1'b1 : (en_clr_i ? 1'b0 : en_q);
    occ_d   = en_clr_i ? '0 : occ_q + SEG_W'(take_ok) - SEG_W'(rel_ok);
    m_d     = m_we_i ? data_i : m_q;
    thr_h_d = thr_h_we_i ? data_i : thr_h_q;
    thr_s_d = thr_s_we_i ? data_i : thr_s_q;
    free_d  = m_d - occ_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      occ_q      <= '0;
      m_q        <= '0;
      thr_h_q    <= '0;
      thr_s_q    <= '0;
      hungry_q   <= 1'b0;
      starving_q <= 1'b0;
    end else begin
      en_q       <= en_d;
      occ_q      <= occ_d;
      m_q        <= m_d;
      thr_h_q    <= thr_h_d;
      thr_s_q    <= thr_s_d;
      hungry_q   <= en_d & (free_d <= thr_h_d);
      starving_q <= en_d & (free_d <= thr_s_d);
    end
  end

  assign en_o       = en_q;
  assign m_o        = m_q;
  assign hungry_o   = hungry_q;
  assign starving_o = starving_q;
endmodule

// File: rtl/seg_pool_alloc.sv
module seg_pool_alloc
  import seg_pool_pkg::*;
#(
  parameter int POOL_SEGS = 508,
  parameter int NCH       = 64,
  localparam int SEG_W    = $clog2(POOL_SEGS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                code_we_i,
  input  logic [2:0]          code_i,
  input  logic                cfg_we_i,
  input  logic [1:0]          cfg_op_i,
  input  logic [CH_IDX_W-1:0] cfg_ch_i,
  input  logic [SEG_W-1:0]    cfg_data_i,
  input  logic                take_i,
  input  logic [CH_IDX_W-1:0] take_ch_i,
  input  logic                rel_i,
  input  logic [CH_IDX_W-1:0] rel_ch_i,
  output logic [2:0]          code_o,
  output logic [SEG_W-1:0]    total_o,
  output logic                alloc_err_o,
  output logic                ch_err_o,
  output logic [NCH-1:0]      hungry_o,
  output logic [NCH-1:0]      starving_o
);
  localparam int SUM_W = SEG_W + 1;
  localparam logic [6:0] NCH_L = 7'(NCH);

  logic [2:0]       code_q;
  logic             locked_q;
  logic [SEG_W-1:0] total_q;
  logic             alloc_err_q, ch_err_q;
  logic [SUM_W-1:0] cap_w, new_total;
  logic [6:0]       chans_w, max_ch_w;
  logic [NCH-1:0]   en_w;
  logic [SEG_W-1:0] m_w [NCH];
  logic             sel_en;
  logic [SEG_W-1:0] sel_m;
  logic             ch_in_range, wr_en, en_req, ch_refuse, wr_al, over, alloc_ok;

  // size code: first legal write wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q   <= CODE_RST;
      locked_q <= 1'b0;
    end else if (code_we_i && !locked_q && code_i <= CODE_MAX) begin
      code_q   <= code_i;
      locked_q <= 1'b1;
    end
  end

  always_comb begin
    unique case (code_q)
      3'd0:    begin chans_w = 7'd1;  cap_w = SUM_W'(POOL_SEGS); end
      3'd1:    begin chans_w = 7'd4;  cap_w = SUM_W'(256); end
      3'd2:    begin chans_w = 7'd8;  cap_w = SUM_W'(128); end
      3'd3:    begin chans_w = 7'd16; cap_w = SUM_W'(64); end
      3'd4:    begin chans_w = 7'd32; cap_w = SUM_W'(32); end
      default: begin chans_w = 7'd64; cap_w = SUM_W'(16); end
    endcase
    max_ch_w = (chans_w > NCH_L) ? NCH_L : chans_w;
  end

  always_comb begin
    sel_en = 1'b0;
    sel_m  = '0;
    for (int i = 0; i < NCH; i++) begin
      if (cfg_ch_i == CH_IDX_W'(i)) begin
        sel_en = en_w[i];
        sel_m  = m_w[i];
      end
    end
  end

  assign ch_in_range = {1'b0, cfg_ch_i} < NCH_L;
  assign wr_en       = cfg_we_i && cfg_op_i == OP_EN;
  assign en_req      = wr_en && cfg_data_i[0];
  assign ch_refuse   = en_req && ({1'b0, cfg_ch_i} >= max_ch_w);
  assign wr_al       = cfg_we_i && cfg_op_i == OP_ALLOC && ch_in_range && !sel_en;
  assign new_total   = SUM_W'(total_q) - SUM_W'(sel_m) + SUM_W'(cfg_data_i);
  assign over        = (SUM_W'(cfg_data_i) > cap_w) || (new_total > SUM_W'(POOL_SEGS));
  assign alloc_ok    = wr_al && !over;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_q     <= '0;
      alloc_err_q <= 1'b0;
      ch_err_q    <= 1'b0;
    end else begin
      if (alloc_ok) total_q <= new_total[SEG_W-1:0];
      alloc_err_q <= wr_al && over;
      ch_err_q    <= ch_refuse;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic hit_cfg;
    assign hit_cfg = cfg_ch_i == CH_IDX_W'(g);
    seg_pool_chan #(.SEG_W(SEG_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_set_i   (hit_cfg && en_req && !ch_refuse),
      .en_clr_i   (hit_cfg && wr_en && !cfg_data_i[0]),
      .m_we_i     (hit_cfg && alloc_ok),
      .thr_h_we_i (hit_cfg && cfg_we_i && cfg_op_i == OP_THR_H),
      .thr_s_we_i (hit_cfg && cfg_we_i && cfg_op_i == OP_THR_S),
      .data_i     (cfg_data_i),
      .take_i     (take_i && take_ch_i == CH_IDX_W'(g)),
      .rel_i      (rel_i && rel_ch_i == CH_IDX_W'(g)),
      .en_o       (en_w[g]),
      .m_o        (m_w[g]),
      .hungry_o   (hungry_o[g]),
      .starving_o (starving_o[g])
    );
  end

  assign code_o      = code_q;
  assign total_o     = total_q;
  assign alloc_err_o = alloc_err_q;
  assign ch_err_o    = ch_err_q;
endmodule

// File: rtl/seg_pool_alloc_chk.sv
module seg_pool_alloc_chk
  import seg_pool_pkg::*;
#(
  parameter int POOL_SEGS = 508,
  parameter int NCH       = 64,
  parameter int SEG_W     = 9
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cfg_we_i,
  input logic [1:0]          cfg_op_i,
  input logic [CH_IDX_W-1:0] cfg_ch_i,
  input logic [SEG_W-1:0]    cfg_data_i,
  input logic [2:0]          code_o,
  input logic [SEG_W-1:0]    total_o,
  input logic                alloc_err_o,
  input logic                ch_err_o,
  input logic [NCH-1:0]      hungry_o,
  input logic [NCH-1:0]      starving_o,
  input logic [NCH-1:0]      en_w,
  input logic [6:0]          max_ch_w,
  input logic [SEG_W:0]      cap_w
);
  logic [2:0] prev_code_q;
  logic       chg_q;
  logic       ch_on;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_code_q <= CODE_RST;
      chg_q       <= 1'b0;
    end else begin
      prev_code_q <= code_o;
      if (code_o != prev_code_q) chg_q <= 1'b1;
    end
  end

  always_comb begin
    ch_on = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (cfg_ch_i == CH_IDX_W'(i)) ch_on = en_w[i];
  end

  p_code_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_q |-> code_o == prev_code_q);

  p_total_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    total_o <= SEG_W'(POOL_SEGS));

  p_range_err_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_op_i == OP_EN && cfg_data_i[0] && {1'b0, cfg_ch_i} >= max_ch_w)
    |=> ch_err_o);

  p_cap_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_op_i == OP_ALLOC && {1'b0, cfg_ch_i} < 7'(NCH) && !ch_on
     && {1'b0, cfg_data_i} > cap_w) |=> alloc_err_o);

  p_locked_alloc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_op_i == OP_ALLOC && ch_on) |=> (!alloc_err_o && $stable(total_o)));

  p_flags_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hungry_o | starving_o) & ~en_w) == '0);
endmodule

bind seg_pool_alloc seg_pool_alloc_chk #(
  .POOL_SEGS(POOL_SEGS), .NCH(NCH), .SEG_W(SEG_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_op_i(cfg_op_i),
  .cfg_ch_i(cfg_ch_i), .cfg_data_i(cfg_data_i), .code_o(code_o), .total_o(total_o),
  .alloc_err_o(alloc_err_o), .ch_err_o(ch_err_o), .hungry_o(hungry_o),
  .starving_o(starving_o), .en_w(en_w), .max_ch_w(max_ch_w), .cap_w(cap_w)
);

// File: tb/sim_seg_pool_alloc.sv
`timescale 1ns/1ps
module sim_seg_pool_alloc;
  localparam int CLK_PERIOD = 10;
  localparam int POOL = 508;
  localparam int NCH  = 8;
  localparam int SEG_W = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic code_we = 1'b0;
  logic [2:0] code = '0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_op = '0;
  logic [5:0] cfg_ch = '0, take_ch = '0, rel_ch = '0;
  logic [SEG_W-1:0] cfg_data = '0;
  logic take = 1'b0, rel = 1'b0;
  logic [2:0] code_o;
  logic [SEG_W-1:0] total_o;
  logic alloc_err, ch_err;
  logic [NCH-1:0] hungry, starving;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_pool_alloc #(.POOL_SEGS(POOL), .NCH(NCH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .code_we_i(code_we), .code_i(code),
    .cfg_we_i(cfg_we), .cfg_op_i(cfg_op), .cfg_ch_i(cfg_ch), .cfg_data_i(cfg_data),
    .take_i(take), .take_ch_i(take_ch), .rel_i(rel), .rel_ch_i(rel_ch),
    .code_o(code_o), .total_o(total_o), .alloc_err_o(alloc_err), .ch_err_o(ch_err),
    .hungry_o(hungry), .starving_o(starving)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic code_wr(int c);
    @(negedge clk) begin code_we = 1'b1; code = 3'(c); end
    @(negedge clk) code_we = 1'b0;
  endtask

  task automatic cfg(int op, int ch, int d);
    @(negedge clk) begin cfg_we = 1'b1; cfg_op = 2'(op); cfg_ch = 6'(ch); cfg_data = SEG_W'(d); end
    @(negedge clk) cfg_we = 1'b0;
  endtask

  task automatic take_one(int ch);
    @(negedge clk) begin take = 1'b1; take_ch = 6'(ch); end
    @(negedge clk) take = 1'b0;
  endtask

  task automatic rel_one(int ch);
    @(negedge clk) begin rel = 1'b1; rel_ch = 6'(ch); end
    @(negedge clk) rel = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int occ, fr;
    // R2 sweep over every legal size code
    for (int c = 0; c < 6; c++) begin
      int nch, cap, eff;
      do_reset();
      code_wr(c);
      check("R3 code taken", int'(code_o), c);
      nch = (c == 0) ? 1 : (1 << (c + 1));
      cap = (c == 0) ? POOL : (1 << (9 - c));
      eff = (nch < NCH) ? nch : NCH;
      cfg(1, 0, cap + 1);
      check("R6 over cap err", int'(alloc_err), 1);
      check("R6 over cap total", int'(total_o), 0);
      cfg(1, 0, cap);
      check("R2 cap accepted err", int'(alloc_err), 0);
      check("R2 cap accepted total", int'(total_o), cap);
      cfg(0, eff - 1, 1);
      check("R2 last channel ok", int'(ch_err), 0);
      cfg(0, eff, 1);
      check("R4 range err", int'(ch_err), 1);
      if (eff < NCH) check("R4 refused stays off", int'(hungry[eff]), 0);
    end

    // R1 reset state and R3 locking
    do_reset();
    check("R1 code", int'(code_o), 3);
    check("R1 total", int'(total_o), 0);
    check("R1 errs", int'({alloc_err, ch_err}), 0);
    check("R1 flags", int'({hungry, starving}), 0);
    code_wr(6);
    check("R3 illegal ignored", int'(code_o), 3);
    code_wr(2);
    check("R3 first write", int'(code_o), 2);
    code_wr(4);
    check("R3 locked", int'(code_o), 2);

    // R8 R9 R10 occupancy sweep on channel 0
    cfg(1, 0, 24);
    cfg(3, 0, 4);
    cfg(2, 0, 6);
    cfg(0, 0, 1);
    check("R10 start hungry", int'(hungry[0]), 0);
    for (int k = 1; k <= 26; k++) begin
      take_one(0);
      occ = (k < 24) ? k : 24;
      fr = 24 - occ;
      check("R8 R10 hungry on take", int'(hungry[0]), int'(fr <= 6));
      check("R8 R9 starving on take", int'(starving[0]), int'(fr <= 4));
    end
    cfg(1, 0, 30);
    check("R5 enabled alloc no err", int'(alloc_err), 0);
    check("R5 enabled alloc total", int'(total_o), 24);
    for (int k = 1; k <= 25; k++) begin
      rel_one(0);
      occ = (k < 24) ? 24 - k : 0;
      fr = 24 - occ;
      check("R8 R10 hungry on release", int'(hungry[0]), int'(fr <= 6));
      check("R8 R9 starving on release", int'(starving[0]), int'(fr <= 4));
    end

    // R11 disable clears flags and occupancy
    for (int k = 0; k < 20; k++) take_one(0);
    check("R9 starving at 4 free", int'(starving[0]), 1);
    cfg(0, 0, 0);
    check("R11 flags cleared", int'({hungry[0], starving[0]}), 0);
    take_one(0);
    check("R8 take while off", int'(hungry[0]), 0);
    cfg(0, 0, 1);
    check("R11 re-enable flags", int'({hungry[0], starving[0]}), 0);
    for (int k = 0; k < 19; k++) take_one(0);
    check("R11 occupancy restarted hungry", int'(hungry[0]), 1);
    check("R11 occupancy restarted starving", int'(starving[0]), 0);
    cfg(3, 0, 5);
    check("R9 threshold change", int'(starving[0]), 1);

    // R7 pool total boundary
    for (int ch = 1; ch <= 3; ch++) cfg(1, ch, 128);
    check("R7 total after fill", int'(total_o), 408);
    cfg(1, 4, 101);
    check("R7 overflow err", int'(alloc_err), 1);
    check("R7 overflow total", int'(total_o), 408);
    cfg(1, 4, 100);
    check("R7 exact pool err", int'(alloc_err), 0);
    check("R7 exact pool total", int'(total_o), 508);
    cfg(1, 5, 1);
    check("R7 one past pool", int'(alloc_err), 1);
    cfg(1, 1, 0);
    check("R5 off channel realloc", int'(total_o), 380);
    check("R6 no err on shrink", int'(alloc_err), 0);

    finish_run();
  end
endmodule